// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns a single asynchronous serial input line into characters. The frame shape is chosen at runtime through a set of configuration inputs. Parity can be present or absent, and when present it can be odd or even. There can be seven or eight data bits, sent least or most significant first, and one or two stop bits. The bit period is given as a count of clock cycles on a divisor input, which equals the clock frequency divided by the baud rate: at 3 MHz, 312 gives 9600 baud and 26 gives 115200 baud.

Each completed character is checked for parity and stop-bit errors and for the all-zero break pattern. It is then either accepted into a one-entry receive buffer, which raises a ready flag, or rejected, depending on two filter options. Sticky error flags record framing, parity and overrun events, and a summary flag is the OR of the three. A one-cycle read strobe consumes the buffer and clears the ready flag and every error flag. A busy output shows that a frame is being sampled.

Top module: `uart_rx_core`

## Requirements
- R1: A falling edge on the line starts a frame only if the line is still low at the middle of the start bit. A low pulse shorter than half a bit period raises neither the ready flag nor any error flag.
- R2: `cfg_seven_bit` = 1 selects 7 data bits and 0 selects 8. `cfg_msb_first` = 1 means the first data bit on the line is the most significant and 0 means it is the least significant. A 7-bit character appears in `rx_data_o[6:0]` with bit 7 reading 0.
- R3: With `cfg_par_en` = 1, a parity bit follows the data. With `cfg_par_even` = 1 the data bits and the parity bit together hold an even number of ones, and with 0 an odd number. A mismatch sets `err_parity_o`. While `cfg_par_en` = 0, `err_parity_o` reads 0.
- R4: A stop bit sampled low sets `err_frame_o`. With `cfg_two_stop` = 1 both stop bits are checked.
- R5: `err_overrun_o` is set when a character is accepted while `rx_ready_o` is still 1 and no read occurs in that cycle. The buffer then holds the newer character.
- R6: `err_any_o` is 1 exactly when at least one of `err_frame_o`, `err_parity_o` or `err_overrun_o` is 1.
- R7: A one-cycle `rd_i` pulse clears `rx_ready_o`, `err_frame_o`, `err_parity_o` and `err_overrun_o` on the next cycle.
- R8: A non-break character with a parity or framing error is accepted only when `cfg_keep_err` = 1. When it is rejected, `rx_ready_o` and `rx_data_o` keep their values, but its error flags are still recorded.
- R9: A break is a frame whose data bits, parity bit (if any) and first stop bit are all low. It is accepted only when `cfg_keep_brk` = 1, whatever `cfg_keep_err` says.
- R10: `busy_o` is 1 from start-bit detection until the last stop bit has been sampled.
- R11: Every bit lasts `baud_div` clock cycles. Each bit after the start bit is sampled one bit period after the previous sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial input line, idle high |
| baud_div | input | DIV_W | Clock cycles per bit |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 even parity, 0 odd |
| cfg_msb_first | input | 1 | 1 MSB first, 0 LSB first |
| cfg_seven_bit | input | 1 | 1 seven data bits, 0 eight |
| cfg_two_stop | input | 1 | 1 two stop bits, 0 one |
| cfg_keep_err | input | 1 | Accept characters with errors |
| cfg_keep_brk | input | 1 | Accept break characters |
| rd_i | input | 1 | Buffer read strobe |
| rx_data_o | output | 8 | Receive buffer |
| rx_ready_o | output | 1 | Unread character in buffer |
| err_frame_o | output | 1 | Framing error flag |
| err_parity_o | output | 1 | Parity error flag |
| err_overrun_o | output | 1 | Overrun flag |
| err_any_o | output | 1 | Summary error flag |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench targets the cases where the filter and the flags interact. A rejected erroneous character must leave the buffer and the ready flag unchanged while its flag still appears. A break must be accepted with the error filter off when the break option is on, which a design that applied the error filter first would refuse. A second unread character must raise overrun, and a design that compared against the wrong ready state would miss it. It also sends a glitch shorter than half a bit, which a receiver without mid-bit validation would turn into a phantom character. It checks that the parity flag is hidden once parity is disabled, and it runs seven-bit MSB-first frames, where a wrong bit-position mapping would shift the data.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_HOLD
  } rx_state_e;

  // index of the last data bit for the chosen width
  function automatic logic [2:0] last_bit_idx(input logic seven);
    return seven ? 3'd6 : 3'd7;
  endfunction

  // buffer position of the idx-th bit seen on the line
  function automatic logic [2:0] bit_pos(input logic [2:0] idx,
                                         input logic msb_first,
                                         input logic seven);
    return msb_first ? (last_bit_idx(seven) - idx) : idx;
  endfunction

  // 1 when data plus parity bit match the selected sense
  function automatic logic parity_ok(input logic [7:0] data,
                                     input logic par_bit,
                                     input logic even);
    logic ones_odd;
    ones_odd = (^data) ^ par_bit;
    return even ? !ones_odd : ones_odd;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             start_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start_i)      cnt_q <= baud_div >> 1;
    else if (tick_o)       cnt_q <= baud_div - 1'b1;
    else if (run_i)        cnt_q <= cnt_q - 1'b1;
  end

  // R11
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $stable(baud_div) && baud_div != '0) |-> (cnt_q < baud_div));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_s,
  input  logic       tick_i,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_msb_first,
  input  logic       cfg_seven_bit,
  input  logic       cfg_two_stop,
  output logic       start_o,
  output logic       run_o,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       ev_fe_o,
  output logic       ev_pe_o,
  output logic       ev_brk_o,
  output logic       busy_o
);
  rx_state_e  state_q;
  logic [2:0] idx_q;
  logic [7:0] data_q;
  logic       par_q, stop1_q, stop2_q, done_q;

  assign start_o = (state_q == ST_IDLE) && !rx_s;
  assign run_o   = (state_q != ST_IDLE) && (state_q != ST_HOLD);
  assign busy_o  = run_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      data_q  <= '0;
      par_q   <= 1'b0;
      stop1_q <= 1'b1;
      stop2_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (!rx_s) begin
          state_q <= ST_START;
          idx_q   <= '0;
          data_q  <= '0;
          par_q   <= 1'b0;
          stop2_q <= 1'b1;
        end
        ST_START: if (tick_i) state_q <= rx_s ? ST_IDLE : ST_DATA;
        ST_DATA: if (tick_i) begin
          data_q[bit_pos(idx_q, cfg_msb_first, cfg_seven_bit)] <= rx_s;
          idx_q <= idx_q + 3'd1;
          if (idx_q == last_bit_idx(cfg_seven_bit))
            state_q <= cfg_par_en ? ST_PAR : ST_STOP1;
        end
        ST_PAR: if (tick_i) begin
          par_q   <= rx_s;
          state_q <= ST_STOP1;
        end
        ST_STOP1: if (tick_i) begin
          stop1_q <= rx_s;
          if (cfg_two_stop) state_q <= ST_STOP2;
          else begin
            state_q <= ST_HOLD;
            done_q  <= 1'b1;
          end
        end
        ST_STOP2: if (tick_i) begin
          stop2_q <= rx_s;
          state_q <= ST_HOLD;
          done_q  <= 1'b1;
        end
        ST_HOLD: if (rx_s) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign data_o   = data_q;
  assign ev_fe_o  = !stop1_q || (cfg_two_stop && !stop2_q);
  assign ev_pe_o  = cfg_par_en && !parity_ok(data_q, par_q, cfg_par_even);
  assign ev_brk_o = (data_q == 8'h00) && (!cfg_par_en || !par_q) && !stop1_q;

  // R10
  busy_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_o));

  // R1
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && tick_i && rx_s) |=> (state_q == ST_IDLE && !done_q));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_i,
  input  logic [7:0] data_i,
  input  logic       ev_fe_i,
  input  logic       ev_pe_i,
  input  logic       ev_brk_i,
  input  logic       keep_err_i,
  input  logic       keep_brk_i,
  input  logic       rd_i,
  output logic [7:0] buf_o,
  output logic       ready_o,
  output logic       fe_o,
  output logic       pe_o,
  output logic       oe_o
);
  logic [7:0] buf_q;
  logic       ready_q, fe_q, pe_q, oe_q;
  logic       accept_w, store_w;

  assign accept_w = ev_brk_i ? keep_brk_i : (!(ev_fe_i || ev_pe_i) || keep_err_i);
  assign store_w  = done_i && accept_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      ready_q <= 1'b0;
      fe_q    <= 1'b0;
      pe_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      fe_q    <= (fe_q && !rd_i) || (done_i && ev_fe_i);
      pe_q    <= (pe_q && !rd_i) || (done_i && ev_pe_i);
      oe_q    <= (oe_q && !rd_i) || (store_w && ready_q && !rd_i);
      ready_q <= store_w || (ready_q && !rd_i);
      if (store_w) buf_q <= data_i;
    end
  end

  assign buf_o   = buf_q;
  assign ready_o = ready_q;
  assign fe_o    = fe_q;
  assign pe_o    = pe_q;
  assign oe_o    = oe_q;

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !done_i) |=> (!ready_q && !fe_q && !pe_q && !oe_q));

  // R5
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> ($past(ready_q) && $past(done_i)));

  // R8
  reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !accept_w && !rd_i) |=> (ready_q == $past(ready_q) && $stable(buf_q)));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             cfg_par_en,
  input  logic             cfg_par_even,
  input  logic             cfg_msb_first,
  input  logic             cfg_seven_bit,
  input  logic             cfg_two_stop,
  input  logic             cfg_keep_err,
  input  logic             cfg_keep_brk,
  input  logic             rd_i,
  output logic [7:0]       rx_data_o,
  output logic             rx_ready_o,
  output logic             err_frame_o,
  output logic             err_parity_o,
  output logic             err_overrun_o,
  output logic             err_any_o,
  output logic             busy_o
);
  logic       rx_s, tick_w, start_w, run_w, done_w;
  logic       ev_fe_w, ev_pe_w, ev_brk_w, pe_flag_w;
  logic [7:0] frame_data_w;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s));

  uart_rx_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div),
    .start_i(start_w), .run_i(run_w), .tick_o(tick_w));

  uart_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .tick_i(tick_w),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_msb_first(cfg_msb_first), .cfg_seven_bit(cfg_seven_bit),
    .cfg_two_stop(cfg_two_stop),
    .start_o(start_w), .run_o(run_w), .done_o(done_w), .data_o(frame_data_w),
    .ev_fe_o(ev_fe_w), .ev_pe_o(ev_pe_w), .ev_brk_o(ev_brk_w), .busy_o(busy_o));

  uart_rx_status u_status (
    .clk(clk), .rst_n(rst_n), .done_i(done_w), .data_i(frame_data_w),
    .ev_fe_i(ev_fe_w), .ev_pe_i(ev_pe_w), .ev_brk_i(ev_brk_w),
    .keep_err_i(cfg_keep_err), .keep_brk_i(cfg_keep_brk), .rd_i(rd_i),
    .buf_o(rx_data_o), .ready_o(rx_ready_o), .fe_o(err_frame_o),
    .pe_o(pe_flag_w), .oe_o(err_overrun_o));

  // R3 parity flag hidden while parity is off
  assign err_parity_o = pe_flag_w && cfg_par_en;
  // R6
  assign err_any_o    = err_frame_o || err_parity_o || err_overrun_o;
endmodule

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [15:0] div = 16'd16;
  logic par_en = 0, par_even = 0, msb = 0, seven = 0, two = 0, keep_err = 0, keep_brk = 0, rd = 0;
  logic [7:0] data;
  logic ready, fe, pe, oe, any, busy;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  uart_rx_core i_uart_rx_core (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_div(div),
    .cfg_par_en(par_en), .cfg_par_even(par_even), .cfg_msb_first(msb),
    .cfg_seven_bit(seven), .cfg_two_stop(two), .cfg_keep_err(keep_err),
    .cfg_keep_brk(keep_brk), .rd_i(rd),
    .rx_data_o(data), .rx_ready_o(ready), .err_frame_o(fe), .err_parity_o(pe),
    .err_overrun_o(oe), .err_any_o(any), .busy_o(busy));

  // {data, par_en even msb seven two bad_par bad_stop keep_err keep_brk, ready fe pe, exp_data}
  localparam logic [27:0] VEC [0:8] = '{
    {8'hA5, 9'b000000000, 3'b100, 8'hA5},  // R2 8 bit lsb
    {8'h3C, 9'b111000000, 3'b100, 8'h3C},  // R2 R3 msb even
    {8'h5A, 9'b100110000, 3'b100, 8'h5A},  // R2 R3 R4 7 bit odd two stop
    {8'hC3, 9'b110001000, 3'b001, 8'h00},  // R8 rejected parity error
    {8'hC3, 9'b110001010, 3'b101, 8'hC3},  // R8 kept parity error
    {8'h81, 9'b001000100, 3'b010, 8'h00},  // R4 R8 rejected bad stop
    {8'h00, 9'b000000110, 3'b010, 8'h00},  // R9 break rejected
    {8'h00, 9'b110000101, 3'b110, 8'h00},  // R9 break kept
    {8'h6E, 9'b111100000, 3'b100, 8'h6E}   // R2 7 bit msb
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    rx = b;
    repeat (int'(div)) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    int n;
    logic [7:0] m;
    n = seven ? 7 : 8;
    m = seven ? (d & 8'h7F) : d;
    bit_out(1'b0);
    for (int i = 0; i < n; i++) bit_out(msb ? m[n-1-i] : m[i]);
    if (par_en) bit_out((par_even ? ^m : ~^m) ^ bad_par);
    bit_out(!bad_stop);
    if (two) bit_out(1'b1);
    rx = 1'b1;
    repeat (2 * int'(div)) @(negedge clk);
  endtask

  task automatic read_buf();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R7 reset ready", {7'd0, ready}, 8'd0);
    chk("R6 reset flags", {4'd0, fe, pe, oe, any}, 8'd0);
    chk("R10 reset busy", {7'd0, busy}, 8'd0);

    foreach (VEC[k]) begin
      {par_en, par_even, msb, seven, two} = VEC[k][19:15];
      keep_err = VEC[k][12];
      keep_brk = VEC[k][11];
      send(VEC[k][27:20], VEC[k][14], VEC[k][13]);
      chk($sformatf("R8 R9 ready v%0d", k), {7'd0, ready}, {7'd0, VEC[k][10]});
      chk($sformatf("R4 frame v%0d", k), {7'd0, fe}, {7'd0, VEC[k][9]});
      chk($sformatf("R3 parity v%0d", k), {7'd0, pe}, {7'd0, VEC[k][8]});
      chk($sformatf("R6 any v%0d", k), {7'd0, any}, {7'd0, VEC[k][9] | VEC[k][8]});
      if (VEC[k][10]) chk($sformatf("R2 data v%0d", k), data, VEC[k][7:0]);
      read_buf();
      chk($sformatf("R7 cleared v%0d", k), {4'd0, ready, fe, pe, oe}, 8'd0);
    end

    // R8 rejected character leaves buffer data alone
    {par_en, par_even, msb, seven, two, keep_err, keep_brk} = 7'b1100000;
    send(8'h42, 1'b0, 1'b0);
    send(8'h99, 1'b1, 1'b0);
    chk("R8 rejected keeps data", data, 8'h42);
    chk("R8 rejected keeps ready", {7'd0, ready}, 8'd1);
    // R3 parity flag hidden when parity disabled
    par_en = 1'b0;
    @(negedge clk);
    chk("R3 masked parity", {6'd0, pe, any}, 8'd0);
    read_buf();

    // R5 overrun on second unread character
    send(8'h11, 1'b0, 1'b0);
    send(8'h22, 1'b0, 1'b0);
    chk("R5 overrun flag", {7'd0, oe}, 8'd1);
    chk("R6 overrun any", {7'd0, any}, 8'd1);
    chk("R5 newer data", data, 8'h22);
    read_buf();
    chk("R7 overrun cleared", {6'd0, oe, any}, 8'd0);

    // R1 glitch shorter than half a bit
    rx = 1'b0;
    repeat (3) @(negedge clk);
    rx = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 glitch ready", {7'd0, ready}, 8'd0);
    chk("R1 glitch flags", {5'd0, fe, pe, oe}, 8'd0);
    chk("R1 glitch busy", {7'd0, busy}, 8'd0);

    // R10 busy mid-frame, R11 divisor 26
    div = 16'd26;
    @(negedge clk);
    fork
      send(8'hE7, 1'b0, 1'b0);
      begin
        repeat (26 * 4) @(negedge clk);
        chk("R10 busy mid frame", {7'd0, busy}, 8'd1);
      end
    join
    chk("R11 divisor 26 data", data, 8'hE7);
    chk("R11 divisor 26 ready", {7'd0, ready}, 8'd1);
    chk("R10 idle after frame", {7'd0, busy}, 8'd0);
    read_buf();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule